// File: doc/BRIEF.md
# Two-Register Store Decoder and Sequencer

This block takes one 32-bit store-pair instruction word and turns it into memory traffic. A select pin states whether the word uses the fixed-width layout or the compact two-halfword layout. The block decodes the first and second source registers, the base register, a zero-extended offset and the indexing controls. It classifies the word as legal, undefined, unpredictable, or belonging to some other instruction.

A legal word runs a fixed sequence. The block reads the base register through a single combinational register read port and forms the address. It writes the first register and then the second register as two beats on a valid/ready write channel. If writeback applies, it then drives the updated address onto a one-cycle writeback port. A one-cycle `done` pulse closes every instruction, and the status flags are valid during that pulse.

Instructions enter on a valid/ready channel. `ins_ready` is high only while the block is idle, so each word is taken in exactly one cycle and any `ins_valid` seen while busy is ignored. On the write channel, once `mem_valid` is high the block holds the beat until `mem_ready` is seen high at a rising edge. The upstream side may stall for any number of cycles.

Top module: `dsq_unit`

## Requirements
- R1: Field layout for both encodings: bit 24 = pre-index, bit 23 = add, bit 21 = W, bits 19:16 = base, bits 15:12 = first register. The compact word carries its first halfword in bits 31:16. A word is foreign (`foreign` set in the `done` cycle) when: fixed-width and bits 27:25 are not 000, bit 22 is not 1, bit 20 is not 0, or bits 7:4 are not 1111; or compact and bits 31:25 are not 1110100, bit 22 is not 1, bit 20 is not 0, or bits 24 and 21 are both 0.
- R2: Offset is zero-extended. For the compact encoding it is bits 7:0 times 4. For the fixed-width encoding it is {bits 11:8, bits 3:0}.
- R3: The updated address is base plus offset when add is 1, and base minus offset when add is 0. The first beat's address is the updated address when pre-index is 1, and the unmodified base otherwise.
- R4: Writeback is W for the compact encoding, and (pre-index is 0 or W is 1) for the fixed-width encoding. When set, exactly one cycle of `wb_en` follows the second beat, carrying the base register number and the updated address. `done` follows in the next cycle.
- R5: The second register is bits 11:8 for the compact encoding and the first register plus one for the fixed-width encoding.
- R6: A fixed-width word with an odd first register is undefined.
- R7: A fixed-width word is unpredictable when any of these holds: pre-index is 0 with W set; the second register is 15; or writeback is set and the base is 15 or equals either source register.
- R8: A compact word is unpredictable when any of these holds: the base is 15; either source register is 13 or 15; or writeback is set and the base equals either source register.
- R9: Priority is foreign, then undefined, then unpredictable, so at most one flag is set. A flagged word causes no memory beat and no writeback, and its `done` follows acceptance by one cycle.
- R10: The first beat writes the first register at the access address. The second writes the second register at that address plus 4. Address and data hold stable while `mem_valid` is high and `mem_ready` is low.
- R11: `ins_ready` is high only when idle. `done` is a single-cycle pulse per accepted word.
- R12: After reset the block is idle: `ins_ready` is 1, and `mem_valid`, `wb_en`, `done` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Block idle and taking a word |
| ins_word | input | 32 | Instruction word |
| ins_compact | input | 1 | 1 = compact encoding, 0 = fixed-width |
| rd_addr | output | 4 | Register read index |
| rd_data | input | 32 | Register read value (combinational) |
| mem_valid | output | 1 | Write beat offered |
| mem_ready | input | 1 | Write beat taken |
| mem_addr | output | 32 | Write address |
| mem_data | output | 32 | Write data |
| wb_en | output | 1 | Base register writeback strobe |
| wb_addr | output | 4 | Writeback register index |
| wb_data | output | 32 | Writeback value |
| done | output | 1 | Instruction finished (one cycle) |
| flt_undef | output | 1 | Undefined, valid with done |
| flt_unpred | output | 1 | Unpredictable, valid with done |
| foreign | output | 1 | Not this instruction, valid with done |

## Verification
The main function is exercised with a range of words in both encodings:

- Offset and indexing: pre- and post-indexed forms, add and subtract, and the largest offsets, with and without writeback. These separate the two offset formations and the two writeback rules. A fixed-width word with pre-index and W both clear must write back; the same bits in the compact encoding must be reported foreign.
- Illegal cases: each one is hit alone, and one word combines an odd register with pre-index clear and W set to check priority.
- Legal near-misses: a base of 15 without writeback, and a compact base equal to a source register without writeback. These confirm that the hazard checks depend on writeback.
- Back-pressure: every other vector runs with a stalling write channel, so beat ordering and hold stability are checked under stalls.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam int unsigned DW = 32;      // data and address width
  localparam int unsigned RW = 4;       // register index width
  localparam int unsigned BEAT_BYTES = DW / 8;
  localparam logic [RW-1:0] REG_PC = RW'(15);
  localparam logic [RW-1:0] REG_SP = RW'(13);

  typedef enum logic [2:0] {
    ST_IDLE, ST_BASE, ST_BEAT0, ST_BEAT1, ST_WB, ST_FIN
  } st_e;

  typedef struct packed {
    logic [RW-1:0] rt;
    logic [RW-1:0] rt2;
    logic [RW-1:0] rn;
    logic [DW-1:0] off;
    logic          pre;
    logic          add;
    logic          wback;
    logic          foreign;
    logic          undef;
    logic          unpred;
  } dec_t;
endpackage

// File: rtl/dsq_decode.sv
module dsq_decode
  import dsq_pkg::*;
(
  input  logic [31:0] word,
  input  logic        compact,
  output dec_t        dec
);
  logic          p_bit, u_bit, w_bit;
  logic [RW-1:0] rn, rt, rt2;
  logic          wbk, frn, und, unp;
  logic [DW-1:0] off;

  assign p_bit = word[24];
  assign u_bit = word[23];
  assign w_bit = word[21];
  assign rn    = word[19:16];
  assign rt    = word[15:12];

  function automatic logic bad_reg(input logic [RW-1:0] r);
    return (r == REG_SP) || (r == REG_PC);
  endfunction

  always_comb begin
    off = '0;
    if (compact) begin
      rt2       = word[11:8];
      off[9:0]  = {word[7:0], 2'b00};
      wbk       = w_bit;
      frn       = (word[31:25] != 7'b1110100) || !word[22] || word[20] ||
                  (!p_bit && !w_bit);
      und       = 1'b0;
      unp       = (rn == REG_PC) || bad_reg(rt) || bad_reg(rt2) ||
                  (wbk && ((rn == rt) || (rn == rt2)));
    end else begin
      rt2       = rt + RW'(1);
      off[7:0]  = {word[11:8], word[3:0]};
      wbk       = !p_bit || w_bit;
      frn       = (word[27:25] != 3'b000) || !word[22] || word[20] ||
                  (word[7:4] != 4'hF);
      und       = rt[0];
      unp       = (!p_bit && w_bit) || (rt2 == REG_PC) ||
                  (wbk && ((rn == REG_PC) || (rn == rt) || (rn == rt2)));
    end
  end

  always_comb begin
    dec         = '0;
    dec.rt      = rt;
    dec.rt2     = rt2;
    dec.rn      = rn;
    dec.off     = off;
    dec.pre     = p_bit;
    dec.add     = u_bit;
    dec.wback   = wbk;
    dec.foreign = frn;
    dec.undef   = !frn && und;
    dec.unpred  = !frn && !und && unp;
  end
endmodule

// File: rtl/dsq_agen.sv
module dsq_agen
  import dsq_pkg::*;
(
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] off,
  input  logic          pre,
  input  logic          add,
  output logic [DW-1:0] acc_addr,
  output logic [DW-1:0] nxt_addr
);
  assign nxt_addr = add ? (base + off) : (base - off);
  assign acc_addr = pre ? nxt_addr : base;
endmodule

// File: rtl/dsq_ctrl.sv
module dsq_ctrl
  import dsq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  dec_t          dec_in,
  output dec_t          cur,
  output logic [RW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] acc_addr,
  input  logic [DW-1:0] nxt_addr,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          wb_en,
  output logic [RW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  output logic          done,
  output logic          flt_undef,
  output logic          flt_unpred,
  output logic          foreign
);
  st_e           st;
  logic [DW-1:0] a0, wbv;
  logic          bad_in;

  assign bad_in = dec_in.foreign || dec_in.undef || dec_in.unpred;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cur <= '0;
      a0  <= '0;
      wbv <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (ins_valid) begin
          cur <= dec_in;
          st  <= bad_in ? ST_FIN : ST_BASE;
        end
        ST_BASE: begin
          a0  <= acc_addr;
          wbv <= nxt_addr;
          st  <= ST_BEAT0;
        end
        ST_BEAT0: if (mem_ready) st <= ST_BEAT1;
        ST_BEAT1: if (mem_ready) st <= cur.wback ? ST_WB : ST_FIN;
        ST_WB:    st <= ST_FIN;
        ST_FIN:   st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      ST_BEAT0: rd_addr = cur.rt;
      ST_BEAT1: rd_addr = cur.rt2;
      default:  rd_addr = cur.rn;
    endcase
  end

  assign ins_ready  = (st == ST_IDLE);
  assign mem_valid  = (st == ST_BEAT0) || (st == ST_BEAT1);
  assign mem_addr   = (st == ST_BEAT1) ? (a0 + DW'(BEAT_BYTES)) : a0;
  assign mem_data   = rd_data;
  assign wb_en      = (st == ST_WB);
  assign wb_addr    = cur.rn;
  assign wb_data    = wbv;
  assign done       = (st == ST_FIN);
  assign flt_undef  = done && cur.undef;
  assign flt_unpred = done && cur.unpred;
  assign foreign    = done && cur.foreign;

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

  p_second_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && (st == ST_BEAT0) |=>
      mem_valid && (mem_addr == $past(mem_addr) + DW'(BEAT_BYTES)));

  p_wb_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> done && !wb_en);

  p_no_store_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !(cur.undef || cur.unpred || cur.foreign));

  p_flags_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0({flt_undef, flt_unpred, foreign}));

  p_busy_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_ready |=> $stable(cur));
endmodule

// File: rtl/dsq_unit.sv
module dsq_unit
  import dsq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [31:0]   ins_word,
  input  logic          ins_compact,
  output logic [RW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          wb_en,
  output logic [RW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  output logic          done,
  output logic          flt_undef,
  output logic          flt_unpred,
  output logic          foreign
);
  dec_t          dec_w, cur_w;
  logic [DW-1:0] acc_w, nxt_w;

  dsq_decode u_dec (
    .word    (ins_word),
    .compact (ins_compact),
    .dec     (dec_w)
  );

  dsq_agen u_agen (
    .base     (rd_data),
    .off      (cur_w.off),
    .pre      (cur_w.pre),
    .add      (cur_w.add),
    .acc_addr (acc_w),
    .nxt_addr (nxt_w)
  );

  dsq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_valid  (ins_valid),
    .ins_ready  (ins_ready),
    .dec_in     (dec_w),
    .cur        (cur_w),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .acc_addr   (acc_w),
    .nxt_addr   (nxt_w),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .wb_en      (wb_en),
    .wb_addr    (wb_addr),
    .wb_data    (wb_data),
    .done       (done),
    .flt_undef  (flt_undef),
    .flt_unpred (flt_unpred),
    .foreign    (foreign)
  );
endmodule

// File: tb/dsq_unit_bench.sv
module dsq_unit_bench;
  localparam int PERIOD = 10;
  localparam int NV = 23;

  typedef struct packed {
    logic [31:0] word;
    logic        cmp;
    logic [1:0]  kind;   // 0 legal, 1 undefined, 2 unpredictable, 3 foreign
    logic [31:0] addr;
    logic [3:0]  rt2;
    logic        wb;
    logic [31:0] wbv;
  } vec_t;

  // register i holds (i+1) << 12
  localparam vec_t VECS [NV] = '{
    '{32'hE1C243F4, 1'b0, 2'd0, 32'h00003034, 4'd5,  1'b0, 32'h0},      // R1 R2 R3 R5 pre add
    '{32'hE16361F0, 1'b0, 2'd0, 32'h00003FF0, 4'd7,  1'b1, 32'h3FF0},   // R3 R4 subtract wb
    '{32'hE0C18FFF, 1'b0, 2'd0, 32'h00002000, 4'd9,  1'b1, 32'h20FF},   // R4 post, P=W=0 writes back
    '{32'hE1CF43F4, 1'b0, 2'd0, 32'h00010034, 4'd5,  1'b0, 32'h0},      // R7 base 15 no wb legal
    '{32'hE1C233F4, 1'b0, 2'd1, 32'h0,        4'd0,  1'b0, 32'h0},      // R6 odd rt
    '{32'hE0E243F4, 1'b0, 2'd2, 32'h0,        4'd0,  1'b0, 32'h0},      // R7 P=0 W=1
    '{32'hE1C2E3F4, 1'b0, 2'd2, 32'h0,        4'd0,  1'b0, 32'h0},      // R7 rt2 = 15
    '{32'hE16661F0, 1'b0, 2'd2, 32'h0,        4'd0,  1'b0, 32'h0},      // R7 base = rt wb
    '{32'hE16761F0, 1'b0, 2'd2, 32'h0,        4'd0,  1'b0, 32'h0},      // R7 base = rt2 wb
    '{32'hE16F61F0, 1'b0, 2'd2, 32'h0,        4'd0,  1'b0, 32'h0},      // R7 base 15 wb
    '{32'hE0E233F4, 1'b0, 2'd1, 32'h0,        4'd0,  1'b0, 32'h0},      // R9 undef beats unpred
    '{32'hE1C243D4, 1'b0, 2'd3, 32'h0,        4'd0,  1'b0, 32'h0},      // R1 bits 7:4
    '{32'hE1D243F4, 1'b0, 2'd3, 32'h0,        4'd0,  1'b0, 32'h0},      // R1 bit 20
    '{32'hE9C24905, 1'b1, 2'd0, 32'h00003014, 4'd9,  1'b0, 32'h0},      // R2 R5 compact
    '{32'hE9650140, 1'b1, 2'd0, 32'h00005F00, 4'd1,  1'b1, 32'h5F00},   // R3 R4 compact sub wb
    '{32'hE8E0ACFF, 1'b1, 2'd0, 32'h00001000, 4'd12, 1'b1, 32'h13FC},   // R2 R4 compact post max
    '{32'hE8C24905, 1'b1, 2'd3, 32'h0,        4'd0,  1'b0, 32'h0},      // R1 compact P=W=0
    '{32'hE9CF4905, 1'b1, 2'd2, 32'h0,        4'd0,  1'b0, 32'h0},      // R8 base 15
    '{32'hE9C2D905, 1'b1, 2'd2, 32'h0,        4'd0,  1'b0, 32'h0},      // R8 rt 13
    '{32'hE9C24F05, 1'b1, 2'd2, 32'h0,        4'd0,  1'b0, 32'h0},      // R8 rt2 15
    '{32'hE9610140, 1'b1, 2'd2, 32'h0,        4'd0,  1'b0, 32'h0},      // R8 base = rt2 wb
    '{32'hE9824905, 1'b1, 2'd3, 32'h0,        4'd0,  1'b0, 32'h0},      // R1 compact bit 22
    '{32'hE9C44905, 1'b1, 2'd0, 32'h00005014, 4'd9,  1'b0, 32'h0}       // R8 base = rt no wb legal
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, ins_compact = 1'b0, mem_ready = 1'b1;
  logic [31:0] ins_word = '0;
  logic ins_ready, mem_valid, wb_en, done, flt_undef, flt_unpred, foreign;
  logic [3:0] rd_addr, wb_addr;
  logic [31:0] rd_data, mem_addr, mem_data, wb_data;

  int checks = 0, errors = 0, cyc = 0;
  bit stall = 1'b0, finished = 1'b0;
  int nbeats, done_cnt;
  logic [31:0] ba [2];
  logic [31:0] bd [2];
  bit wb_seen;
  logic [3:0] wb_a;
  logic [31:0] wb_d;
  logic [1:0] kind_seen;
  bit prev_stall;
  logic [31:0] prev_addr, prev_data;

  always #(PERIOD/2) clk = ~clk;
  assign rd_data = (32'(rd_addr) + 32'd1) << 12;

  dsq_unit u_dsq_unit (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .ins_compact(ins_compact), .rd_addr(rd_addr),
    .rd_data(rd_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .wb_en(wb_en), .wb_addr(wb_addr),
    .wb_data(wb_data), .done(done), .flt_undef(flt_undef),
    .flt_unpred(flt_unpred), .foreign(foreign)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: drives back-pressure at negedge, samples 3 time units later
  initial begin
    prev_stall = 1'b0;
    forever begin
      @(negedge clk);
      mem_ready = stall ? ((cyc % 3) == 2) : 1'b1;
      cyc++;
      #3;
      if (rst_n) begin
        if (prev_stall) begin
          chk(mem_valid, "R10 hold valid", 32'(mem_valid), 32'd1);
          chk(mem_addr == prev_addr, "R10 hold addr", mem_addr, prev_addr);
          chk(mem_data == prev_data, "R10 hold data", mem_data, prev_data);
        end
        if (mem_valid && mem_ready) begin
          if (nbeats < 2) begin
            ba[nbeats] = mem_addr;
            bd[nbeats] = mem_data;
          end
          nbeats++;
        end
        if (wb_en) begin
          wb_seen = 1'b1;
          wb_a = wb_addr;
          wb_d = wb_data;
        end
        if (done) begin
          done_cnt++;
          kind_seen = foreign ? 2'd3 : flt_unpred ? 2'd2 : flt_undef ? 2'd1 : 2'd0;
          chk($countones({flt_undef, flt_unpred, foreign}) <= 1, "R9 one flag",
              32'({flt_undef, flt_unpred, foreign}), 32'd0);
        end
        prev_stall = mem_valid && !mem_ready;
        prev_addr  = mem_addr;
        prev_data  = mem_data;
      end
    end
  end

  task automatic run_vec(input vec_t v, input int idx);
    logic [3:0] rt, rn;
    rt = v.word[15:12];
    rn = v.word[19:16];
    @(negedge clk);
    nbeats = 0; done_cnt = 0; wb_seen = 1'b0; kind_seen = 2'd0;
    stall = idx[0];
    ins_word = v.word; ins_compact = v.cmp; ins_valid = 1'b1;
    #3;
    chk(ins_ready, "R11 ready when idle", 32'(ins_ready), 32'd1);
    @(negedge clk);
    ins_valid = 1'b0;
    #3;
    chk(!ins_ready, "R11 busy after accept", 32'(ins_ready), 32'd0);
    wait (done_cnt != 0);
    chk(kind_seen == v.kind, "R1 R6 R7 R8 class", 32'(kind_seen), 32'(v.kind));
    if (v.kind == 2'd0) begin
      chk(nbeats == 2, "R10 two beats", 32'(nbeats), 32'd2);
      chk(ba[0] == v.addr, "R2 R3 first addr", ba[0], v.addr);
      chk(ba[1] == v.addr + 32'd4, "R10 second addr", ba[1], v.addr + 32'd4);
      chk(bd[0] == (32'(rt) + 1) << 12, "R10 first data", bd[0], (32'(rt) + 1) << 12);
      chk(bd[1] == (32'(v.rt2) + 1) << 12, "R5 second data", bd[1], (32'(v.rt2) + 1) << 12);
      chk(wb_seen == v.wb, "R4 writeback enable", 32'(wb_seen), 32'(v.wb));
      if (v.wb) begin
        chk(wb_a == rn, "R4 writeback reg", 32'(wb_a), 32'(rn));
        chk(wb_d == v.wbv, "R4 writeback value", wb_d, v.wbv);
      end
    end else begin
      chk(nbeats == 0, "R9 no beats on fault", 32'(nbeats), 32'd0);
      chk(!wb_seen, "R9 no writeback on fault", 32'(wb_seen), 32'd0);
    end
    @(negedge clk);
    #3;
    chk(done_cnt == 1, "R11 single done", 32'(done_cnt), 32'd1);
    chk(ins_ready, "R11 idle after done", 32'(ins_ready), 32'd1);
  endtask

  // R9 timing: flagged word finishes the cycle after acceptance
  task automatic fault_timing;
    @(negedge clk);
    stall = 1'b0; done_cnt = 0;
    ins_word = 32'hE1C233F4; ins_compact = 1'b0; ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    #3;
    chk(done && flt_undef, "R9 done next cycle", 32'({done, flt_undef}), 32'd3);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 50000);
    if (!finished) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    chk(ins_ready && !mem_valid && !wb_en && !done && !flt_undef && !flt_unpred && !foreign,
        "R12 reset state", {25'd0, ins_ready, mem_valid, wb_en, done, flt_undef, flt_unpred, foreign},
        32'h40);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk(ins_ready && !mem_valid && !done, "R12 idle after release",
        32'({ins_ready, mem_valid, done}), 32'h4);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
    fault_timing();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule